// File: doc/BRIEF.md
# Register-Mapped Byte Serial Port

This block is a serial port that sits on an APB bus and moves 8N1 frames: one start bit, eight data bits sent least significant bit first, and one stop bit. Each direction holds one byte instead of a queue. A 20-bit divider sets how many bus clock cycles each bit lasts. Software loads a byte by writing the data word, and it collects a received byte by reading that same word.

Status flags show whether each one-byte holding buffer is full, and whether a byte was overwritten before it was used. These overrun flags are sticky. Four interrupt lines come out of the block: transmit, receive, transmit overrun and receive overrun. A fifth line is the OR of those four. The transmit and receive interrupt bits are latched by events. The two overrun interrupt bits are not latched: each follows its status flag combined with its enable.

The receiver passes the line through two synchronizing flops. It confirms the start bit half a bit period after the falling edge, and then samples every later bit in the middle of its period.

Top module: `apb_byte_uart`

## Requirements
- R1: The bus has zero wait states: pready is always 1 and pslverr is always 0. Word offsets are: 0x00 data, 0x04 status, 0x08 control, 0x0C interrupt status, 0x10 divider. Reads of any other offset outside the identification window return 0, and writes to them change nothing.
- R2: The twelve words from 0xFD0 to 0xFFC are read-only and return, in address order: 04,00,00,00,21,B8,1B,00,0D,F0,05,B1.
- R3: The control word keeps only bits [6:0]. Bit 0 enables transmit, bit 1 enables receive, bit 2 enables the TX interrupt, bit 3 the RX interrupt, bit 4 the TX-overrun interrupt and bit 5 the RX-overrun interrupt. Bit 6 is stored and has no function. The divider keeps only bits [19:0].
- R4: txd idles high. A frame is a low start bit, the data bits LSB first and a high stop bit, and each bit lasts exactly one divider count of clock cycles.
- R5: A data write sets TX-full (status bit 0). TX-full clears when the byte moves into the shifter, which happens only when transmit is enabled and the shifter is idle. That move latches the TX interrupt (interrupt status bit 0) when bit 2 of the control word is set.
- R6: Writing data while TX-full is set sets TX overrun (status bit 2), and the new byte replaces the waiting one.
- R7: When receive is enabled, a frame with a good stop bit stores its byte, sets RX-full (status bit 1), and latches the RX interrupt (interrupt status bit 1) when bit 3 of the control word is set.
- R8: A frame that arrives while receive is disabled is discarded. A frame whose stop bit samples low is also discarded.
- R9: A byte that arrives while RX-full is set sets RX overrun (status bit 3). The exception is a byte that arrives in the same cycle as a data read: it only refills the buffer, and RX-full stays set.
- R10: A data read returns the received byte in bits [7:0] and clears RX-full.
- R11: Writing 1 to status bit 2 or bit 3 clears that bit. Writes to status bits 0 and 1 have no effect.
- R12: Interrupt status bits 2 and 3 always equal the TX or RX overrun flag ANDed with its enable. Writing 1 to any interrupt status bit clears it, and writing 1 to bit 2 or bit 3 also clears the matching overrun flag. When a set and a clear fall in the same cycle, the set wins.
- R13: irq_tx, irq_rx, irq_txovr and irq_rxovr follow interrupt status bits 0 to 3, and irq_any is their OR.
- R14: Reset clears every register, both buffers and every interrupt. While the divider is below 16, neither shifter starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and bit-timing clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; bits [1:0] ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit buffer drained interrupt |
| irq_rx | output | 1 | Byte received interrupt |
| irq_txovr | output | 1 | Transmit overrun interrupt |
| irq_rxovr | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of the four interrupts |

## Verification
The conflict that matters is a data read that lands in the same cycle as a second byte coming in while RX-full is set. Here the buffer refills, RX-full stays set and no overrun may be flagged. The bench computes the stop-bit sample cycle from the divider and the synchronizer delay, and it times a read so that its access edge falls on that cycle. It then checks that the status word shows RX-full without RX overrun and that the next read returns the new byte. The other conflicts are a data write while a byte is waiting and a clear racing a set, and these are covered with directed bursts.

// File: rtl/byte_uart_pkg.sv
package byte_uart_pkg;

  localparam int unsigned MIN_DIV = 16;

  // word indices (byte offset / 4) whose positions software depends on
  localparam logic [9:0] W_DATA  = 10'h000;
  localparam logic [9:0] W_STAT  = 10'h001;
  localparam logic [9:0] W_CTRL  = 10'h002;
  localparam logic [9:0] W_INT   = 10'h003;
  localparam logic [9:0] W_DIV   = 10'h004;
  localparam logic [9:0] W_ID_LO = 10'h3F4;
  localparam logic [9:0] W_ID_HI = 10'h3FF;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HIGH
  } rx_state_e;

  function automatic logic div_valid(input logic [31:0] d);
    return d >= MIN_DIV;
  endfunction

  function automatic logic [31:0] half_period(input logic [31:0] d);
    return d >> 1;
  endfunction

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    return 8'h04;
      4'd4:    return 8'h21;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h1B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/byte_uart_tx.sv
module byte_uart_tx #(
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [7:0]       byte_in,
  input  logic [DIV_W-1:0] div,
  output logic             load,
  output logic             busy,
  output logic             txd
);
  localparam int FRAME_BITS = 10;

  logic [FRAME_BITS-1:0] shreg;
  logic [DIV_W-1:0]      cnt;
  logic [3:0]            nbit;
  logic                  bit_end;

  assign load    = go && !busy;
  assign bit_end = (cnt >= div - 1'b1);
  assign txd     = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      cnt   <= '0;
      nbit  <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      shreg <= {1'b1, byte_in, 1'b0};
      cnt   <= '0;
      nbit  <= '0;
      busy  <= 1'b1;
    end else if (busy) begin
      if (bit_end) begin
        cnt   <= '0;
        shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
        if (nbit == 4'(FRAME_BITS - 1)) busy <= 1'b0;
        else                            nbit <= nbit + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/byte_uart_rx.sv
module byte_uart_rx
  import byte_uart_pkg::*;
#(
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rxd,
  input  logic [DIV_W-1:0] div,
  output logic             done,
  output logic [7:0]       byte_out
);
  logic [1:0]       sync;
  logic             rxs;
  rx_state_e        st;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       nbit;
  logic [7:0]       shreg;
  logic             bit_end;
  logic             half_end;

  assign rxs      = sync[1];
  assign bit_end  = (cnt >= div - 1'b1);
  assign half_end = (32'(cnt) + 32'd1 >= half_period(32'(div)));
  assign done     = (st == RX_STOP) && bit_end && rxs;
  assign byte_out = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      nbit  <= '0;
      shreg <= '0;
    end else begin
      case (st)
        RX_IDLE: if (en && !rxs) begin
          st  <= RX_START;
          cnt <= '0;
        end
        RX_START: if (half_end) begin
          cnt  <= '0;
          nbit <= '0;
          st   <= rxs ? RX_IDLE : RX_DATA;
        end else cnt <= cnt + 1'b1;
        RX_DATA: if (bit_end) begin
          cnt   <= '0;
          shreg <= {rxs, shreg[7:1]};
          if (nbit == 3'd7) st <= RX_STOP;
          else              nbit <= nbit + 1'b1;
        end else cnt <= cnt + 1'b1;
        RX_STOP: if (bit_end) begin
          cnt <= '0;
          st  <= rxs ? RX_IDLE : RX_WAIT_HIGH;
        end else cnt <= cnt + 1'b1;
        RX_WAIT_HIGH: if (rxs) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/apb_byte_uart.sv
module apb_byte_uart
  import byte_uart_pkg::*;
#(
  parameter int DIV_W  = 20,
  parameter int ADDR_W = 12
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_txovr,
  output logic              irq_rxovr,
  output logic              irq_any
);
  localparam int WORD_W = ADDR_W - 2;

  logic [6:0]       ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       txbuf, rxbuf;
  logic             txfull, rxfull, txovr, rxovr;
  logic             txint_q, rxint_q;
  logic [3:0]       int_stat;

  logic [WORD_W-1:0] word;
  logic wr_acc, rd_acc;
  logic data_wr, data_rd, stat_wr, ctrl_wr, int_wr, div_wr;
  logic baud_ok, tx_go, tx_load, tx_busy, rx_en_eff, rx_done, rx_accept;
  logic ctrl_tx_en, ctrl_rx_en, ctrl_tx_ie, ctrl_rx_ie, ctrl_txo_ie, ctrl_rxo_ie;
  logic [7:0] rx_byte;
  logic unused_bits;

  assign unused_bits = ^{pwdata[31:DIV_W], paddr[1:0]};

  // decoded bus events
  assign word    = paddr[ADDR_W-1:2];
  assign wr_acc  = psel && penable && pwrite;
  assign rd_acc  = psel && penable && !pwrite;
  assign data_wr = wr_acc && (word == WORD_W'(W_DATA));
  assign data_rd = rd_acc && (word == WORD_W'(W_DATA));
  assign stat_wr = wr_acc && (word == WORD_W'(W_STAT));
  assign ctrl_wr = wr_acc && (word == WORD_W'(W_CTRL));
  assign int_wr  = wr_acc && (word == WORD_W'(W_INT));
  assign div_wr  = wr_acc && (word == WORD_W'(W_DIV));

  assign ctrl_tx_en  = ctrl_q[0];
  assign ctrl_rx_en  = ctrl_q[1];
  assign ctrl_tx_ie  = ctrl_q[2];
  assign ctrl_rx_ie  = ctrl_q[3];
  assign ctrl_txo_ie = ctrl_q[4];
  assign ctrl_rxo_ie = ctrl_q[5];

  assign baud_ok   = div_valid(32'(div_q));
  assign tx_go     = ctrl_tx_en && txfull && baud_ok;
  assign rx_en_eff = ctrl_rx_en && baud_ok;
  assign rx_accept = rx_done && ctrl_rx_en;

  byte_uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(pclk), .rst_n(presetn), .go(tx_go), .byte_in(txbuf), .div(div_q),
    .load(tx_load), .busy(tx_busy), .txd(txd)
  );

  byte_uart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(pclk), .rst_n(presetn), .en(rx_en_eff), .rxd(rxd), .div(div_q),
    .done(rx_done), .byte_out(rx_byte)
  );

  // configuration registers
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= pwdata[6:0];
      if (div_wr)  div_q  <= pwdata[DIV_W-1:0];
    end
  end

  // buffers and status flags: sets take priority over clears
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      txbuf   <= '0;
      rxbuf   <= '0;
      txfull  <= 1'b0;
      rxfull  <= 1'b0;
      txovr   <= 1'b0;
      rxovr   <= 1'b0;
      txint_q <= 1'b0;
      rxint_q <= 1'b0;
    end else begin
      if (data_wr) txbuf <= pwdata[7:0];

      if (data_wr)      txfull <= 1'b1;
      else if (tx_load) txfull <= 1'b0;

      if (data_wr && txfull) txovr <= 1'b1;
      else if ((stat_wr || int_wr) && pwdata[2]) txovr <= 1'b0;

      if (rx_accept) rxbuf <= rx_byte;

      if (rx_accept)    rxfull <= 1'b1;
      else if (data_rd) rxfull <= 1'b0;

      if (rx_accept && rxfull && !data_rd) rxovr <= 1'b1;
      else if ((stat_wr || int_wr) && pwdata[3]) rxovr <= 1'b0;

      if (tx_load && ctrl_tx_ie)    txint_q <= 1'b1;
      else if (int_wr && pwdata[0]) txint_q <= 1'b0;

      if (rx_accept && ctrl_rx_ie)  rxint_q <= 1'b1;
      else if (int_wr && pwdata[1]) rxint_q <= 1'b0;
    end
  end

  assign int_stat  = {rxovr && ctrl_rxo_ie, txovr && ctrl_txo_ie, rxint_q, txint_q};
  assign irq_tx    = int_stat[0];
  assign irq_rx    = int_stat[1];
  assign irq_txovr = int_stat[2];
  assign irq_rxovr = int_stat[3];
  assign irq_any   = |int_stat;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (word == WORD_W'(W_DATA))      prdata = {24'd0, rxbuf};
      else if (word == WORD_W'(W_STAT)) prdata = {28'd0, rxovr, txovr, rxfull, txfull};
      else if (word == WORD_W'(W_CTRL)) prdata = {25'd0, ctrl_q};
      else if (word == WORD_W'(W_INT))  prdata = {28'd0, int_stat};
      else if (word == WORD_W'(W_DIV))  prdata = 32'(div_q);
      else if (word >= WORD_W'(W_ID_LO) && word <= WORD_W'(W_ID_HI))
        prdata = {24'd0, id_byte(4'(word - WORD_W'(W_ID_LO)))};
    end
  end
endmodule

// File: rtl/byte_uart_chk.sv
module byte_uart_chk (
  input logic pclk,
  input logic presetn,
  input logic rx_done,
  input logic ctrl_rx_en,
  input logic ctrl_tx_ie,
  input logic rxfull,
  input logic rxovr,
  input logic data_rd,
  input logic tx_busy,
  input logic tx_load,
  input logic txd,
  input logic txfull,
  input logic irq_tx,
  input logic baud_ok
);
  p_rx_store_r7: assert property (@(posedge pclk) disable iff (!presetn)
    rx_done && ctrl_rx_en |=> rxfull);

  p_rx_overrun_r9: assert property (@(posedge pclk) disable iff (!presetn)
    rx_done && ctrl_rx_en && rxfull && !data_rd |=> rxovr);

  p_read_clears_r10: assert property (@(posedge pclk) disable iff (!presetn)
    data_rd && !(rx_done && ctrl_rx_en) |=> !rxfull);

  p_idle_high_r4: assert property (@(posedge pclk) disable iff (!presetn)
    !tx_busy |-> txd);

  p_drain_irq_r5: assert property (@(posedge pclk) disable iff (!presetn)
    $fell(txfull) && $past(ctrl_tx_ie) |-> irq_tx);

  p_no_shift_bad_div_r14: assert property (@(posedge pclk) disable iff (!presetn)
    tx_load |-> baud_ok);
endmodule

bind apb_byte_uart byte_uart_chk u_chk (
  .pclk(pclk), .presetn(presetn), .rx_done(rx_done), .ctrl_rx_en(ctrl_rx_en),
  .ctrl_tx_ie(ctrl_tx_ie), .rxfull(rxfull), .rxovr(rxovr), .data_rd(data_rd),
  .tx_busy(tx_busy), .tx_load(tx_load), .txd(txd), .txfull(txfull),
  .irq_tx(irq_tx), .baud_ok(baud_ok)
);

// File: tb/apb_byte_uart_tb.sv
`timescale 1ns/1ps
module apb_byte_uart_tb;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, rxd, txd;
  logic        irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;

  int checks = 0, errors = 0;
  int cur_div = 16;
  logic [7:0] tx_log [0:63];
  int tx_cnt = 0;
  logic [31:0] rd;

  always #2.5 pclk = ~pclk;

  apb_byte_uart u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txovr(irq_txovr),
    .irq_rxovr(irq_rxovr), .irq_any(irq_any)
  );

  function automatic logic [7:0] exp_id(input int i);
    logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h21, 8'hB8, 8'h1B, 8'h00,
                           8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  function automatic logic [31:0] exp_stat(input logic tf, rf, to, ro);
    return {28'd0, ro, to, rf, tf};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk);
    penable = 1;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk);
    penable = 1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  task automatic drive_rx(input logic [7:0] b, input logic stop_bit, input int div);
    logic [9:0] fr;
    fr = {stop_bit, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rxd = fr[i];
      repeat (div) @(negedge pclk);
    end
    rxd = 1'b1;
    repeat (2 * div) @(negedge pclk);
  endtask

  task automatic wait_tx(input int target);
    for (int i = 0; i < 4000 && tx_cnt < target; i++) @(negedge pclk);
  endtask

  // serial line monitor: samples txd in the middle of each bit
  initial begin
    forever begin
      @(negedge pclk);
      if (presetn && txd == 1'b0) begin
        logic [7:0] b;
        logic st;
        repeat (cur_div / 2) @(negedge pclk);
        st = txd;
        for (int k = 0; k < 8; k++) begin
          repeat (cur_div) @(negedge pclk);
          b[k] = txd;
        end
        repeat (cur_div) @(negedge pclk);
        chk(st == 1'b0 && txd == 1'b1, "R4 framing", {30'd0, st, txd}, 32'h1);
        if (tx_cnt < 64) tx_log[tx_cnt] = b;
        tx_cnt++;
        repeat (cur_div / 2 - 1) @(negedge pclk);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge pclk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rxd = 1'b1;
    void'($urandom(32'h5EED_2024));
    repeat (4) @(negedge pclk);
    presetn = 1'b1;

    // reset state
    chk(pready && !pslverr, "R1 handshake", {30'd0, pready, pslverr}, 32'h2);
    chk(txd && !irq_any, "R14 reset outputs", {30'd0, txd, irq_any}, 32'h2);
    apb_rd(12'h004, rd); chk(rd == 0, "R14 status reset", rd, 0);
    apb_rd(12'h008, rd); chk(rd == 0, "R14 ctrl reset", rd, 0);
    apb_rd(12'h00C, rd); chk(rd == 0, "R14 int reset", rd, 0);
    apb_rd(12'h010, rd); chk(rd == 0, "R14 div reset", rd, 0);

    // identification and unmapped
    for (int i = 0; i < 12; i++) begin
      apb_rd(12'hFD0 + 12'(4 * i), rd);
      chk(rd == {24'd0, exp_id(i)}, "R2 id word", rd, {24'd0, exp_id(i)});
    end
    apb_wr(12'hFD0, 32'hFF);
    apb_rd(12'hFD0, rd); chk(rd == 32'h04, "R2 id read-only", rd, 32'h04);
    apb_wr(12'h014, 32'hFFFF_FFFF);
    apb_rd(12'h014, rd); chk(rd == 0, "R1 unmapped 0x14", rd, 0);
    apb_rd(12'h800, rd); chk(rd == 0, "R1 unmapped 0x800", rd, 0);

    // field widths
    apb_wr(12'h008, 32'hFFFF_FFFF);
    apb_rd(12'h008, rd); chk(rd == 32'h7F, "R3 ctrl width", rd, 32'h7F);
    apb_wr(12'h010, 32'hABCD_E123);
    apb_rd(12'h010, rd); chk(rd == 32'h000D_E123, "R3 div width", rd, 32'h000D_E123);
    apb_wr(12'h008, 32'h0);

    // invalid divider keeps shifter idle
    apb_wr(12'h010, 32'd15);
    apb_wr(12'h008, 32'h05);
    apb_wr(12'h000, 32'h5A);
    begin
      int lows = 0;
      for (int i = 0; i < 100; i++) begin @(negedge pclk); if (!txd) lows++; end
      chk(lows == 0, "R14 no shift with div 15", lows, 0);
    end
    apb_rd(12'h004, rd); chk(rd == exp_stat(1,0,0,0), "R14 byte held", rd, exp_stat(1,0,0,0));
    cur_div = 16;
    apb_wr(12'h010, 32'd16);
    wait_tx(1);
    chk(tx_cnt == 1 && tx_log[0] == 8'h5A, "R4 first frame", {24'd0, tx_log[0]}, 32'h5A);
    apb_rd(12'h004, rd); chk(rd == 0, "R5 txfull cleared", rd, 0);
    chk(irq_tx && irq_any, "R5 tx irq latched", {30'd0, irq_tx, irq_any}, 32'h3);
    apb_wr(12'h00C, 32'h1);
    chk(!irq_tx && !irq_any, "R12 tx irq w1c", {30'd0, irq_tx, irq_any}, 0);

    // transmit overrun: A loads, B waits, C overwrites B
    apb_wr(12'h008, 32'h15);
    apb_wr(12'h000, 32'hA1);
    apb_wr(12'h000, 32'hB2);
    apb_rd(12'h004, rd); chk(rd == exp_stat(1,0,0,0), "R6 no overrun with empty buffer", rd, exp_stat(1,0,0,0));
    apb_wr(12'h000, 32'hC3);
    apb_rd(12'h004, rd); chk(rd == exp_stat(1,0,1,0), "R6 tx overrun flag", rd, exp_stat(1,0,1,0));
    chk(irq_txovr, "R13 txovr line", {31'd0, irq_txovr}, 1);
    apb_rd(12'h00C, rd); chk(rd[2] == 1'b1, "R12 live txovr status", rd, 32'h4);
    wait_tx(3);
    chk(tx_log[1] == 8'hA1 && tx_log[2] == 8'hC3, "R6 replaced byte", {16'd0, tx_log[1], tx_log[2]}, 32'hA1C3);
    apb_wr(12'h00C, 32'h4);
    apb_rd(12'h004, rd); chk(rd[2] == 1'b0, "R12 int w1c clears flag", rd, 0);
    chk(!irq_txovr, "R12 txovr line dropped", {31'd0, irq_txovr}, 0);
    apb_wr(12'h00C, 32'h1);

    // receive
    apb_wr(12'h008, 32'h2A);
    drive_rx(8'h3C, 1'b1, 16);
    apb_rd(12'h004, rd); chk(rd == exp_stat(0,1,0,0), "R7 rxfull set", rd, exp_stat(0,1,0,0));
    chk(irq_rx, "R7 rx irq", {31'd0, irq_rx}, 1);
    apb_rd(12'h000, rd); chk(rd == 32'h3C, "R10 data read", rd, 32'h3C);
    apb_rd(12'h004, rd); chk(rd == 0, "R10 rxfull cleared", rd, 0);
    apb_wr(12'h00C, 32'h2);
    chk(!irq_rx, "R12 rx irq w1c", {31'd0, irq_rx}, 0);

    // receive overrun and status write-one-to-clear
    drive_rx(8'h11, 1'b1, 16);
    drive_rx(8'h22, 1'b1, 16);
    apb_rd(12'h004, rd); chk(rd == exp_stat(0,1,0,1), "R9 rx overrun", rd, exp_stat(0,1,0,1));
    chk(irq_rxovr && irq_any, "R13 rxovr and any", {30'd0, irq_rxovr, irq_any}, 32'h3);
    apb_wr(12'h004, 32'h3);
    apb_rd(12'h004, rd); chk(rd == exp_stat(0,1,0,1), "R11 read-only bits", rd, exp_stat(0,1,0,1));
    apb_wr(12'h004, 32'h8);
    apb_rd(12'h004, rd); chk(rd == exp_stat(0,1,0,0), "R11 w1c overrun", rd, exp_stat(0,1,0,0));
    chk(!irq_rxovr, "R12 rxovr follows flag", {31'd0, irq_rxovr}, 0);
    apb_rd(12'h000, rd); chk(rd == 32'h22, "R9 newest byte kept", rd, 32'h22);
    apb_wr(12'h00C, 32'hF);

    // discarded frames
    apb_wr(12'h008, 32'h08);
    drive_rx(8'h77, 1'b1, 16);
    apb_rd(12'h004, rd); chk(rd == 0, "R8 rx disabled drop", rd, 0);
    chk(!irq_rx, "R8 no irq when disabled", {31'd0, irq_rx}, 0);
    apb_wr(12'h008, 32'h2A);
    drive_rx(8'h66, 1'b0, 16);
    apb_rd(12'h004, rd); chk(rd == 0, "R8 bad stop drop", rd, 0);
    drive_rx(8'h5D, 1'b1, 16);
    apb_rd(12'h000, rd); chk(rd == 32'h5D, "R8 recovery after bad stop", rd, 32'h5D);

    // same-cycle read and arrival
    drive_rx(8'h44, 1'b1, 16);
    fork
      drive_rx(8'h99, 1'b1, 16);
      begin
        logic [31:0] r2;
        repeat (1 + 8 + 9 * 16) @(negedge pclk);
        psel = 1; pwrite = 0; paddr = 12'h000; penable = 0;
        @(negedge pclk);
        penable = 1;
        #1 r2 = prdata;
        @(negedge pclk);
        psel = 0; penable = 0;
        chk(r2 == 32'h44, "R10 read during arrival", r2, 32'h44);
      end
    join
    apb_rd(12'h004, rd); chk(rd == exp_stat(0,1,0,0), "R9 coincident read no overrun", rd, exp_stat(0,1,0,0));
    apb_rd(12'h000, rd); chk(rd == 32'h99, "R9 coincident byte stored", rd, 32'h99);
    apb_wr(12'h00C, 32'hF);

    // constrained random traffic
    for (int it = 0; it < 10; it++) begin
      int d;
      logic [7:0] tb_b, rb;
      logic good;
      d = 16 + int'($urandom % 8);
      tb_b = 8'($urandom);
      rb = 8'($urandom);
      good = ($urandom % 4) != 0;
      cur_div = d;
      apb_wr(12'h010, d);
      apb_wr(12'h008, 32'h3F);
      apb_wr(12'h000, {24'd0, tb_b});
      wait_tx(tx_cnt + 1);
      chk(tx_log[(tx_cnt - 1) % 64] == tb_b, "R4 random tx", {24'd0, tx_log[(tx_cnt - 1) % 64]}, {24'd0, tb_b});
      drive_rx(rb, good, d);
      apb_rd(12'h004, rd);
      chk(rd[1] == good, "R7 random rxfull", rd, {30'd0, good, 1'b0});
      if (good) begin
        apb_rd(12'h000, rd); chk(rd == {24'd0, rb}, "R7 random rx byte", rd, {24'd0, rb});
      end
      apb_wr(12'h00C, 32'hF);
    end

    finish_run();
  end
endmodule